// File: doc/BRIEF.md
# Register-Driven Peripheral Reset Generator

This block drives 64 active-high reset lines for peripherals, under control of a 32-bit memory-mapped register port. Software sets a reset by writing 1 to the line's bit in one of two control words. Most lines then produce a pulse of fixed length and release on their own. Two lines, 12 and 56, latch instead: they stay asserted until software writes 0 to their bit. Software can read the state of every line back through the control words, which read 1 while a line is active, and through two status words, which carry the inverse and so read 0 while a line is active.

Line 0 is the core reset. A write that sets it returns every line in the block to its power-up state in the same edge and starts a pulse on line 0 itself. Each line is a small state machine. Its states are `LN_IDLE` (released), `LN_PULSE` (a timed pulse is running) and `LN_HELD` (a latched line is asserted). Its transitions are: launch (`LN_IDLE` to `LN_PULSE` when a pulse line is set); restart (`LN_PULSE` to `LN_PULSE`, which reloads the count when the line is set again); expire (`LN_PULSE` to `LN_IDLE` when the count runs out); latch (`LN_IDLE` to `LN_HELD` when a latched line is set); unlatch (`LN_HELD` to `LN_IDLE` on a 0 write); and core reset (any state to the power-up state, except on line 0).

Top module: `reset_gen_unit`

## Requirements
- R1: After `rst_n` is released, lines 12 and 56 are asserted and every other line is released.
- R2: Writing 1 to the bit of a pulse line asserts it at the next clock edge. The line stays active for exactly `PULSE_CYC` cycles (default 2) and then releases with no further write.
- R3: Line N is bit N%32 of word N/32. Control word 0 is at offset 0x100 and control word 1 at offset 0x104.
- R4: Status word 0 at 0x150 and status word 1 at 0x154 read back each line inverted: 0 while the line is active, 1 while it is released.
- R5: A control word reads 1 for each active line and 0 for each released line, so a pulse line's bit returns to 0 after its pulse ends.
- R6: Writing 0 to a pulse line during its pulse does not shorten the pulse.
- R7: Writing 1 to a pulse line during its pulse restarts the count, so the line stays active for `PULSE_CYC` cycles after the last write.
- R8: Lines 12 and 56 stay asserted for as long as software leaves them set, and release at the edge of a write of 0 to their bit.
- R9: A write that sets bit 0 of control word 0 puts every other line into its R1 state at that edge and starts a `PULSE_CYC` pulse on line 0.
- R10: Reads of any other offset return 0. Writes to any other offset, including the status words, change no line.
- R11: `bus_rdata` carries the data of a read in the cycle after `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the pulse length is counted in it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on a rising edge |
| bus_rd | input | 1 | Read strobe, sampled on a rising edge |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rst_lines | output | 64 | Active-high reset outputs, one per line |

## Verification
A single pulse shows the launch and expire transitions and the exact pulse length. It is followed by a 0 write that must not shorten the pulse, and by a repeated 1 write that must stretch it by one cycle; together these separate "ignore the clear" from "restart the count". The latched lines are cleared, set again, held for several idle cycles and then released, which tells them apart from pulse lines. A core-reset write made while another pulse is running and the latched lines are down shows that the whole block returns to its power-up state. Writes and reads to status and unmapped offsets confirm that decode touches nothing outside the four words.

// File: rtl/rgu_pkg.sv
package rgu_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_PULSE = 2'd1,
        LN_HELD  = 2'd2
    } line_state_e;
endpackage

// File: rtl/rgu_line.sv
module rgu_line
    import rgu_pkg::*;
#(
    parameter bit STICKY    = 1'b0,
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic active_o
);
    localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);
    localparam line_state_e RST_STATE = STICKY ? LN_HELD : LN_IDLE;

    line_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic act_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LN_IDLE: begin
                if (set_i) begin
                    state_d = STICKY ? LN_HELD : LN_PULSE;
                    cnt_d   = CNT_LOAD;
                end
            end
            LN_PULSE: begin
                if (set_i) begin
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    state_d = LN_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            LN_HELD: begin
                if (clr_i) state_d = LN_IDLE;
            end
            default: state_d = LN_IDLE;
        endcase
        if (soft_rst) begin
            state_d = RST_STATE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= STICKY;
        else        act_q <= (state_d != LN_IDLE);
    end

    assign active_o = act_q;

    assert_pulse_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_PULSE && cnt_q == '0 && !set_i && !soft_rst) |=> !active_o);

    assert_ignore_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_PULSE && cnt_q != '0 && clr_i && !soft_rst) |=> active_o);

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_HELD && !clr_i && !soft_rst) |=> active_o);
endmodule

// File: rtl/rgu_regport.sv
module rgu_regport
    import rgu_pkg::*;
#(
    parameter int          NUM_LINES = 64,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] CTRL_BASE = 12'h100,
    parameter logic [11:0] STAT_BASE = 12'h150
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic [NUM_LINES-1:0] active,
    output logic [NUM_LINES-1:0] set_vec,
    output logic [NUM_LINES-1:0] clr_vec,
    output logic [WORD_W-1:0]    bus_rdata
);
    localparam int WORDS = NUM_LINES / WORD_W;

    logic [WORDS-1:0] ctrl_hit, stat_hit;
    logic [WORD_W-1:0] rd_mux;
    logic rd_hit;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign ctrl_hit[w] = (bus_addr == ADDR_W'(CTRL_BASE + 4 * w));
        assign stat_hit[w] = (bus_addr == ADDR_W'(STAT_BASE + 4 * w));
        assign set_vec[w*WORD_W +: WORD_W] = (bus_wr && ctrl_hit[w]) ? bus_wdata : '0;
        assign clr_vec[w*WORD_W +: WORD_W] = (bus_wr && ctrl_hit[w]) ? ~bus_wdata : '0;
    end

    assign rd_hit = (|ctrl_hit) || (|stat_hit);

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (ctrl_hit[w]) rd_mux = active[w*WORD_W +: WORD_W];
            if (stat_hit[w]) rd_mux = ~active[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !rd_hit) |=> (bus_rdata == '0));

    assert_status_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && stat_hit[0]) |=> (bus_rdata == ~$past(active[WORD_W-1:0])));
endmodule

// File: rtl/reset_gen_unit.sv
module reset_gen_unit
    import rgu_pkg::*;
#(
    parameter int              NUM_LINES   = 64,
    parameter int              ADDR_W      = 12,
    parameter int              PULSE_CYC   = 2,
    parameter logic [63:0]     STICKY_MASK = (64'd1 << 12) | (64'd1 << 56)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] rst_lines
);
    logic [NUM_LINES-1:0] set_vec, clr_vec, active;
    logic core_kill;

    rgu_regport #(
        .NUM_LINES(NUM_LINES),
        .ADDR_W   (ADDR_W)
    ) u_regport (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .active   (active),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .bus_rdata(bus_rdata)
    );

    assign core_kill = set_vec[0];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        rgu_line #(
            .STICKY   (STICKY_MASK[i]),
            .PULSE_CYC(PULSE_CYC)
        ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .soft_rst((i == 0) ? 1'b0 : core_kill),
            .set_i   (set_vec[i]),
            .clr_i   (clr_vec[i]),
            .active_o(active[i])
        );
    end

    assign rst_lines = active;

    assert_core_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_kill |=> (rst_lines[0] &&
            ((rst_lines & NUM_LINES'(STICKY_MASK)) == NUM_LINES'(STICKY_MASK)) &&
            ((rst_lines & ~NUM_LINES'(STICKY_MASK)) == NUM_LINES'(1))));
endmodule

// File: tb/reset_gen_unit_bench.sv
module reset_gen_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] rst_lines;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    localparam logic [63:0] STK = (64'd1 << 12) | (64'd1 << 56);

    always #2 clk = ~clk;

    reset_gen_unit u_reset_gen_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_lines(rst_lines)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: read data is due one cycle after the strobe (R11)
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), {32'd0, bus_rdata}, {32'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", rst_lines, STK);
        rd(12'h100, 32'h0000_1000, "R5 ctrl0 after reset");
        rd(12'h104, 32'h0100_0000, "R3 ctrl1 after reset");
        rd(12'h150, ~32'h0000_1000, "R4 stat0 after reset");
        rd(12'h154, ~32'h0100_0000, "R4 stat1 after reset");

        // pulse on line 3
        wr(12'h100, 32'h0000_1008);
        chk("R2 line3 cycle1", {63'd0, rst_lines[3]}, 64'd1);
        rd(12'h100, 32'h0000_1008, "R5 ctrl0 during pulse");
        chk("R2 line3 cycle2", {63'd0, rst_lines[3]}, 64'd1);
        @(negedge clk);
        chk("R2 line3 released", {63'd0, rst_lines[3]}, 64'd0);
        rd(12'h100, 32'h0000_1000, "R5 ctrl0 after pulse");

        // line 40 = word1 bit 8; clear mid-pulse has no effect
        wr(12'h104, 32'h0100_0100);
        chk("R3 line40 asserted", {63'd0, rst_lines[40]}, 64'd1);
        wr(12'h104, 32'h0100_0000);
        chk("R6 line40 kept", {63'd0, rst_lines[40]}, 64'd1);
        @(negedge clk);
        chk("R6 line40 released on time", {63'd0, rst_lines[40]}, 64'd0);
        chk("R8 line56 still held", {63'd0, rst_lines[56]}, 64'd1);

        // restart on line 63
        wr(12'h104, 32'h8100_0000);
        wr(12'h104, 32'h8100_0000);
        chk("R7 line63 after rewrite", {63'd0, rst_lines[63]}, 64'd1);
        @(negedge clk);
        chk("R7 line63 stretched", {63'd0, rst_lines[63]}, 64'd1);
        @(negedge clk);
        chk("R7 line63 released", {63'd0, rst_lines[63]}, 64'd0);

        // latched lines
        wr(12'h100, 32'h0);
        chk("R8 line12 cleared", {63'd0, rst_lines[12]}, 64'd0);
        rd(12'h150, 32'hFFFF_FFFF, "R4 stat0 all released");
        wr(12'h100, 32'h0000_1000);
        repeat (5) @(negedge clk);
        chk("R8 line12 held", {63'd0, rst_lines[12]}, 64'd1);
        wr(12'h104, 32'h0);
        chk("R8 line56 cleared", {63'd0, rst_lines[56]}, 64'd0);
        rd(12'h154, 32'hFFFF_FFFF, "R4 stat1 all released");

        // core reset while line3 pulses and line 12/56 are down
        wr(12'h100, 32'h0000_0008);
        wr(12'h100, 32'h0000_0001);
        chk("R9 core reset edge", rst_lines, STK | 64'd1);
        @(negedge clk);
        chk("R9 line0 cycle2", rst_lines, STK | 64'd1);
        @(negedge clk);
        chk("R9 line0 released", rst_lines, STK);
        rd(12'h100, 32'h0000_1000, "R9 ctrl0 after core reset");

        // unmapped and read-only offsets
        wr(12'h108, 32'hFFFF_FFFF);
        chk("R10 write 0x108 ignored", rst_lines, STK);
        wr(12'h150, 32'hFFFF_FFFF);
        chk("R10 write status ignored", rst_lines, STK);
        rd(12'h108, 32'h0, "R10 read 0x108");
        rd(12'h000, 32'h0, "R10 read 0x000");
        rd(12'h15C, 32'h0, "R10 read 0x15C");

        repeat (2) @(negedge clk);
        chk("R11 all reads answered", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule